// File: doc/BRIEF.md
# Random Generator Control and Status Registers

This block is the register file for a random number generator. It holds two software-visible words on a simple synchronous bus: a control word and a status word. The control word carries two bits. One enables the generator and the checkers that run beside it. The other enables the interrupt line.

The status word shows three live conditions: sample ready, clock fault and seed fault. It also holds two sticky interrupt flags that record seed and clock faults. Fault detection is done outside this block, in separate logic that drives one event input per condition. A sticky flag is set in hardware and stays set until software writes a zero to its bit. Writing a one to that bit leaves it as it is.

A single interrupt output combines the ready condition and the two sticky flags, and the interrupt enable gates it. The bus has no wait states. A write takes effect at the clock edge where the write strobe is high. With the default configuration, read data is combinational from the address.

Top module: `rng_csr`

## Requirements
- R1: After reset, the control word and the status word both read 0 when all event inputs are low, and `gen_en` and `irq` are 0.
- R2: A write to byte offset 0x0 loads control bit 3 as the interrupt enable and control bit 2 as the generator enable at the next clock edge. `gen_en` follows control bit 2.
- R3: Every control bit other than 3 and 2 reads as 0, and writing those bits has no effect.
- R4: Status bit 0 shows `ev_ready`, bit 1 shows `ev_clk_err` and bit 2 shows `ev_seed_err`, all live. Writes to these bits have no effect on them.
- R5: Status bit 6 (seed fault flag) becomes 1 at the clock edge where `ev_seed_err` is sampled high. It stays 1 after the event drops.
- R6: Status bit 5 (clock fault flag) becomes 1 at the clock edge where `ev_clk_err` is sampled high. It stays 1 after the event drops.
- R7: A write to byte offset 0x4 clears a sticky flag when its bit position is 0 in the write data. A 1 in that position leaves the flag unchanged.
- R8: When a fault event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R9: `irq` is 1 exactly when the interrupt enable is 1 and at least one of `ev_ready`, the seed fault flag or the clock fault flag is 1.
- R10: Reads of any address other than 0x0 and 0x4 return 0. Status bits 3, 4 and 7 and above read 0. Writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| ev_ready | input | 1 | Sample-ready condition from the data path |
| ev_seed_err | input | 1 | Seed fault condition from the seed checker |
| ev_clk_err | input | 1 | Clock fault condition from the clock checker |
| gen_en | output | 1 | Enable for the entropy source and checkers |
| irq | output | 1 | Interrupt request |

## Verification
The bench steps a cycle-level model alongside the design. It sweeps all 16 addresses, every combination of the three event inputs, and many control-write patterns. It targets the write-zero-to-clear rule on each flag separately: if the design cleared on a one, or cleared both flags together, a flag would drop when it should stay set or the wrong flag would drop. The bench also hits the cycle where a fault and a clear coincide, where a design that let the clear win would lose a fault. Writes to reserved and unmapped locations are checked to leave the enables and flags untouched. The interrupt is checked with each source alone under both enable values, which catches a source left out of the combine or a missing enable gate.

// File: rtl/rng_csr_pkg.sv
package rng_csr_pkg;

   // Control word bit positions
   localparam int unsigned CTL_EN_BIT  = 2;
   localparam int unsigned CTL_IE_BIT  = 3;

   // Status word bit positions
   localparam int unsigned ST_RDY_BIT   = 0;
   localparam int unsigned ST_CERR_BIT  = 1;
   localparam int unsigned ST_SERR_BIT  = 2;
   localparam int unsigned ST_CFLAG_BIT = 5;
   localparam int unsigned ST_SFLAG_BIT = 6;

   // Sticky flag indexes
   localparam int unsigned FLAG_CLK  = 0;
   localparam int unsigned FLAG_SEED = 1;
   localparam int unsigned NUM_FLAGS = 2;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2
   } csr_sel_e;

   function automatic int unsigned flag_bit(input int unsigned idx);
      return (idx == FLAG_SEED) ? ST_SFLAG_BIT : ST_CFLAG_BIT;
   endfunction

endpackage

// File: rtl/rng_csr_ctrl.sv
module rng_csr_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_ie,
   input  logic wr_en_bit,
   output logic irq_en,
   output logic gen_en
);

   logic ie_q;
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
         en_q <= 1'b0;
      end else if (wr_en) begin
         ie_q <= wr_ie;
         en_q <= wr_en_bit;
      end
   end

   assign irq_en = ie_q;
   assign gen_en = en_q;

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(ie_q) && $stable(en_q))); // R2

   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (gen_en == $past(wr_en_bit))); // R2

endmodule

// File: rtl/rng_csr_flag.sv
module rng_csr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   // A hardware set takes priority over a software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (clr_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R5

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o); // R7

   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i) |=> flag_o); // R8

endmodule

// File: rtl/rng_csr_irq.sv
module rng_csr_irq #(
   parameter int unsigned NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_en,
   input  logic [NSRC-1:0] src,
   output logic            irq
);

   if (NSRC < 1) begin : g_bad_nsrc
      $error("rng_csr_irq: NSRC must be at least 1");
   end

   assign irq = irq_en & (|src);

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq); // R9

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (src == '0) |-> !irq); // R9

endmodule

// File: rtl/rng_csr.sv
module rng_csr
   import rng_csr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CTRL_OFS  = 0,
   parameter int unsigned STAT_OFS  = 4,
   parameter bit          REG_RDATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_ready,
   input  logic              ev_seed_err,
   input  logic              ev_clk_err,
   output logic              gen_en,
   output logic              irq
);

   localparam int unsigned      MIN_DATA_W = ST_SFLAG_BIT + 1;
   localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] STAT_A    = ADDR_W'(STAT_OFS);

   // Elaboration-time configuration checks
   if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
      $error("rng_csr: DATA_W too narrow for the status word");
   end
   if (CTRL_OFS == STAT_OFS) begin : g_bad_ofs
      $error("rng_csr: control and status offsets collide");
   end
   if ((CTRL_OFS >> ADDR_W) != 0 || (STAT_OFS >> ADDR_W) != 0) begin : g_bad_addr_w
      $error("rng_csr: offsets do not fit in ADDR_W");
   end

   // Address decode
   csr_sel_e sel;
   always_comb begin
      if (bus_addr == CTRL_A)
         sel = SEL_CTRL;
      else if (bus_addr == STAT_A)
         sel = SEL_STAT;
      else
         sel = SEL_NONE;
   end

   logic ctrl_wr;
   logic stat_wr;
   assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
   assign stat_wr = bus_wr && (sel == SEL_STAT);

   // Control word
   logic irq_en;
   rng_csr_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctrl_wr),
      .wr_ie     (bus_wdata[CTL_IE_BIT]),
      .wr_en_bit (bus_wdata[CTL_EN_BIT]),
      .irq_en    (irq_en),
      .gen_en    (gen_en)
   );

   // Sticky fault flags
   logic [NUM_FLAGS-1:0] flag_set;
   logic [NUM_FLAGS-1:0] flag_q;
   assign flag_set[FLAG_CLK]  = ev_clk_err;
   assign flag_set[FLAG_SEED] = ev_seed_err;

   for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      localparam int unsigned BITPOS = flag_bit(gi);
      logic clr_zero;
      assign clr_zero = stat_wr && !bus_wdata[BITPOS];
      rng_csr_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (flag_set[gi]),
         .clr_i  (clr_zero),
         .flag_o (flag_q[gi])
      );
   end

   // Interrupt combine
   rng_csr_irq #(.NSRC(3)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_en (irq_en),
      .src    ({flag_q[FLAG_SEED], flag_q[FLAG_CLK], ev_ready}),
      .irq    (irq)
   );

   // Read-back words
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      ctrl_word               = '0;
      ctrl_word[CTL_IE_BIT]   = irq_en;
      ctrl_word[CTL_EN_BIT]   = gen_en;
      stat_word               = '0;
      stat_word[ST_RDY_BIT]   = ev_ready;
      stat_word[ST_CERR_BIT]  = ev_clk_err;
      stat_word[ST_SERR_BIT]  = ev_seed_err;
      stat_word[ST_CFLAG_BIT] = flag_q[FLAG_CLK];
      stat_word[ST_SFLAG_BIT] = flag_q[FLAG_SEED];
      unique case (sel)
         SEL_CTRL: rd_mux = ctrl_word;
         SEL_STAT: rd_mux = stat_word;
         default:  rd_mux = '0;
      endcase
   end

   if (REG_RDATA) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata_q <= '0;
         else
            rdata_q <= rd_mux;
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

   // Write-data bits without a register behind them
   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   AST_IRQ_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && ev_ready) |-> irq); // R9

   AST_UNMAPPED_NO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_NONE) |=> $stable(gen_en)); // R10

   AST_STAT_WR_NO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> $stable(gen_en)); // R10

endmodule

// File: tb/sim_rng_csr.sv
module sim_rng_csr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ev_ready = 1'b0;
   logic        ev_seed_err = 1'b0;
   logic        ev_clk_err = 1'b0;
   logic        gen_en;
   logic        irq;

   int checks = 0;
   int failures = 0;

   // Bench model state
   logic m_ie = 1'b0, m_en = 1'b0, m_sflag = 1'b0, m_cflag = 1'b0;
   logic cur_rdy = 1'b0, cur_serr = 1'b0, cur_cerr = 1'b0;

   always #5 clk = ~clk;

   rng_csr u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wr      (bus_wr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .ev_ready    (ev_ready),
      .ev_seed_err (ev_seed_err),
      .ev_clk_err  (ev_clk_err),
      .gen_en      (gen_en),
      .irq         (irq)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // One clock cycle of stimulus; model advanced from the requirements
   task automatic cyc(input logic [3:0] a, input logic w, input logic [31:0] d,
                      input logic r, input logic s, input logic c);
      logic n_ie, n_en, n_s, n_c, st_wr;
      bus_addr = a; bus_wr = w; bus_wdata = d;
      ev_ready = r; ev_seed_err = s; ev_clk_err = c;
      n_ie  = (w && a == 4'h0) ? d[3] : m_ie;
      n_en  = (w && a == 4'h0) ? d[2] : m_en;
      st_wr = w && (a == 4'h4);
      n_s   = s | (m_sflag & ~(st_wr & ~d[6]));
      n_c   = c | (m_cflag & ~(st_wr & ~d[5]));
      @(posedge clk);
      #1;
      m_ie = n_ie; m_en = n_en; m_sflag = n_s; m_cflag = n_c;
      cur_rdy = r; cur_serr = s; cur_cerr = c;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // Compare both words and both outputs against the model, no edge crossed
   task automatic verify(input string tag);
      logic [31:0] exp_ctrl, exp_stat;
      exp_ctrl = {28'd0, m_ie, m_en, 2'b00};
      exp_stat = {25'd0, m_sflag, m_cflag, 2'b00, cur_serr, cur_cerr, cur_rdy};
      bus_wr = 1'b0;
      bus_addr = 4'h0; #1;
      check(tag, "ctrl word", bus_rdata, exp_ctrl);
      bus_addr = 4'h4; #1;
      check(tag, "status word", bus_rdata, exp_stat);
      check(tag, "gen_en", {31'd0, gen_en}, {31'd0, m_en});
      check(tag, "irq", {31'd0, irq},
            {31'd0, m_ie & (cur_rdy | m_sflag | m_cflag)});
   endtask

   initial begin : watchdog
      #2000000;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      verify("R1");
      rst_n = 1'b1;
      @(negedge clk);
      verify("R1");

      // R2 / R3: control write patterns, reserved bits must read 0
      for (int i = 0; i < 16; i++) begin
         cyc(4'h0, 1'b1, {8{i[3:0]}} ^ {i[1:0], 30'h2AAAAAA3}, 1'b0, 1'b0, 1'b0);
         verify("R2");
         verify("R3");
      end

      // R4 / R5 / R6 / R9: every event combination, interrupt enabled
      cyc(4'h0, 1'b1, 32'h0000_0008, 1'b0, 1'b0, 1'b0);
      for (int e = 0; e < 8; e++) begin
         cyc(4'h4, 1'b1, 32'hFFFF_FFFF, e[0], e[2], e[1]);
         verify("R4");
         cyc(4'h4, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
         verify("R5");
         verify("R6");
         cyc(4'h4, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
         verify("R7");
      end

      // R7: clear only the seed flag, then only the clock flag
      cyc(4'h0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
      cyc(4'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
      verify("R6");
      cyc(4'h4, 1'b1, 32'h0000_0020, 1'b0, 1'b0, 1'b0);
      verify("R7");
      cyc(4'h4, 1'b1, 32'hFFFF_FFDF, 1'b0, 1'b0, 1'b0);
      verify("R7");

      // R8: fault and clearing write in the same cycle
      cyc(4'h4, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0);
      verify("R8");
      cyc(4'h4, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1);
      verify("R8");
      cyc(4'h4, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
      verify("R8");

      // R9: each source alone under both enable values
      for (int ie = 0; ie < 2; ie++) begin
         for (int src = 0; src < 3; src++) begin
            cyc(4'h0, 1'b1, ie[0] ? 32'h8 : 32'h4, 1'b0, 1'b0, 1'b0);
            cyc(4'h4, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
            cyc(4'h4, 1'b0, 32'h0, src == 0, src == 1, src == 2);
            cyc(4'h4, 1'b0, 32'h0, src == 0, 1'b0, 1'b0);
            verify("R9");
         end
      end

      // R10: unmapped addresses read 0 and writes there change nothing
      cyc(4'h0, 1'b1, 32'h0000_000C, 1'b0, 1'b1, 1'b1);
      for (int a = 0; a < 16; a++) begin
         if (a != 0 && a != 4) begin
            bus_addr = a[3:0]; #1;
            check("R10", "unmapped read", bus_rdata, 32'h0);
            cyc(a[3:0], 1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
            verify("R10");
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule